// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block keeps one 64-bit time counter shared by a configurable number of harts. Each hart also has its own 64-bit compare register and its own software interrupt pending bit. It drives one machine timer interrupt line and one machine software interrupt line per hart. Time does not advance with the clock. The counter steps only when the separately supplied real-time tick input pulses high for a clock cycle. That input must already be synchronous to `clk`.

Software reaches every register through a 32-bit register port. The port has single-cycle requests and registered read data. Each 64-bit register is reached through its low and high words.

A separate clear request input returns the unit to a known time base. It zeroes the counter and the software pending bits. The compare registers are kept unless the `CLR_CMP` parameter is set. In the same step, the clear recomputes every timer interrupt from the zeroed counter without counting a tick.

Top module: `hart_timer_unit`

## Requirements
- R1: The counter rises by exactly one on each clock edge that samples `tick_i` high, including a carry from the low word into the high word. Without a tick, the counter holds its value.
- R2: A `clr_req_i` cycle leaves the counter at zero after the edge. This holds even when a tick or a bus write to the counter arrives in the same cycle.
- R3: After `rst`, every compare register holds all ones. A clear request leaves all compare registers unchanged when `CLR_CMP` is 0, and sets them to zero when it is 1. Bus writes in a clear cycle are dropped.
- R4: A clear request sets every software pending bit to zero after the edge.
- R5: In the cycle that follows a clear request, `mtip_o[h]` is 1 exactly when compare register h is zero. The counter then reads back 0, so no tick was added.
- R6: `mtip_o[h]` is 1 exactly when the counter is greater than or equal to compare register h, using unsigned 64-bit comparison. It reflects each new counter or compare value in the same cycle that value first appears.
- R7: Register map, byte addresses on `bus_addr`:
  - The software pending word of hart h is at 0x0000 + 4h.
  - The low word of compare h is at 0x4000 + 8h, and the high word is at 0x4004 + 8h.
  - The counter low word is at 0xBFF8, and the high word is at 0xBFFC.
- R8: A bus write takes effect on the next edge. A write to either counter word in a tick cycle wins, and that tick is not counted.
- R9: `msip_o[h]` equals bit 0 of the last value written to pending word h. Bits 31:1 of that word read as zero, and writes to them are ignored.
- R10: A read (`bus_en`=1, `bus_we`=0) gives `bus_rvalid`=1 on the next cycle. `bus_rdata` then holds the register value from before that edge. An unmapped address reads 0.
- R11: After `rst`, the counter is 0, all outputs are 0, and `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Real-time tick pulse, synchronous to clk |
| clr_req_i | input | 1 | Soft clear request |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| mtip_o | output | NHARTS | Machine timer interrupt per hart |
| msip_o | output | NHARTS | Machine software interrupt per hart |

## Verification
The bench aims at several corner cases.
- A clear request coinciding with a tick. A design that lets the recompute count time would read back a counter of 1.
- The compare-equals-counter boundary. An off-by-one comparator would raise the timer line one tick late.
- A counter write in a tick cycle. A design that keeps the tick would read back one above the written value.
- The low-to-high word carry, together with writes to the upper pending bits. A faulty design would stall the high word or echo bits that should read as zero.

Long random runs mix ticks, clears and writes of compare values close to the counter. Each timer line is checked every cycle.

// File: rtl/htu_pkg.sv
package htu_pkg;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] SW_BASE  = 16'h0000;
  localparam logic [AW-1:0] CMP_BASE = 16'h4000;
  localparam logic [AW-1:0] CNT_LO   = 16'hBFF8;
  localparam logic [AW-1:0] CNT_HI   = 16'hBFFC;

  function automatic logic [AW-1:0] sw_addr(input int unsigned h);
    return SW_BASE + AW'(4 * h);
  endfunction

  function automatic logic [AW-1:0] cmp_addr(input int unsigned h, input logic hi);
    return CMP_BASE + AW'(8 * h) + (hi ? AW'(4) : AW'(0));
  endfunction
endpackage

// File: rtl/htu_tick_counter.sv
module htu_tick_counter #(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);
  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_d[DW-1:0]  = wdata;
      if (wr_hi) cnt_d[CW-1:DW] = wdata;
    end else if (tick) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/htu_cmp_bank.sv
module htu_cmp_bank #(
  parameter int unsigned NHARTS  = 4,
  parameter int unsigned DW      = 32,
  parameter bit          CLR_CMP = 1'b0,
  localparam int unsigned CW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [NHARTS-1:0]    wr_lo,
  input  logic [NHARTS-1:0]    wr_hi,
  input  logic [DW-1:0]        wdata,
  input  logic [CW-1:0]        cnt_d,
  output logic [NHARTS*CW-1:0] cmp_q,
  output logic [NHARTS-1:0]    mtip_q
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    logic [CW-1:0] cur, nxt;
    assign cur = cmp_q[h*CW +: CW];

    always_comb begin
      nxt = cur;
      if (clr) begin
        if (CLR_CMP) nxt = '0;
      end else begin
        if (wr_lo[h]) nxt[DW-1:0]  = wdata;
        if (wr_hi[h]) nxt[CW-1:DW] = wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[h*CW +: CW] <= '1;
        mtip_q[h]         <= 1'b0;
      end else begin
        cmp_q[h*CW +: CW] <= nxt;
        mtip_q[h]         <= (cnt_d >= nxt);
      end
    end
  end
endmodule

// File: rtl/htu_soft_bank.sv
module htu_soft_bank #(
  parameter int unsigned NHARTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NHARTS-1:0] wr,
  input  logic              wbit,
  output logic [NHARTS-1:0] msip_q
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    always_ff @(posedge clk) begin
      if (rst || clr) msip_q[h] <= 1'b0;
      else if (wr[h]) msip_q[h] <= wbit;
    end
  end
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htu_pkg::*;
#(
  parameter int unsigned NHARTS  = 4,
  parameter int unsigned DW      = 32,
  parameter bit          CLR_CMP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              clr_req_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [NHARTS-1:0] mtip_o,
  output logic [NHARTS-1:0] msip_o
);
  localparam int unsigned CW = 2 * DW;

  logic                 wr_en, rd_en;
  logic [NHARTS-1:0]    sw_hit, cmp_lo_hit, cmp_hi_hit;
  logic                 cnt_lo_hit, cnt_hi_hit;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [NHARTS*CW-1:0] cmp_q;
  logic [DW-1:0]        rd_mux;

  assign wr_en      = bus_en & bus_we;
  assign rd_en      = bus_en & ~bus_we;
  assign cnt_lo_hit = (bus_addr == CNT_LO);
  assign cnt_hi_hit = (bus_addr == CNT_HI);

  for (genvar h = 0; h < NHARTS; h++) begin : g_dec
    assign sw_hit[h]     = (bus_addr == sw_addr(h));
    assign cmp_lo_hit[h] = (bus_addr == cmp_addr(h, 1'b0));
    assign cmp_hi_hit[h] = (bus_addr == cmp_addr(h, 1'b1));
  end

  htu_tick_counter #(.DW(DW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_i),
    .clr   (clr_req_i),
    .wr_lo (wr_en & cnt_lo_hit),
    .wr_hi (wr_en & cnt_hi_hit),
    .wdata (bus_wdata),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  htu_cmp_bank #(.NHARTS(NHARTS), .DW(DW), .CLR_CMP(CLR_CMP)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_req_i),
    .wr_lo  ({NHARTS{wr_en}} & cmp_lo_hit),
    .wr_hi  ({NHARTS{wr_en}} & cmp_hi_hit),
    .wdata  (bus_wdata),
    .cnt_d  (cnt_d),
    .cmp_q  (cmp_q),
    .mtip_q (mtip_o)
  );

  htu_soft_bank #(.NHARTS(NHARTS)) u_sw (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_req_i),
    .wr     ({NHARTS{wr_en}} & sw_hit),
    .wbit   (bus_wdata[0]),
    .msip_q (msip_o)
  );

  always_comb begin
    rd_mux = '0;
    if (cnt_lo_hit) rd_mux = cnt_q[DW-1:0];
    if (cnt_hi_hit) rd_mux = cnt_q[CW-1:DW];
    for (int h = 0; h < NHARTS; h++) begin
      if (sw_hit[h])     rd_mux = {{(DW-1){1'b0}}, msip_o[h]};
      if (cmp_lo_hit[h]) rd_mux = cmp_q[h*CW +: DW];
      if (cmp_hi_hit[h]) rd_mux = cmp_q[h*CW+DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/htu_chk.sv
module htu_chk #(
  parameter int unsigned NHARTS  = 4,
  parameter int unsigned CW      = 64,
  parameter bit          CLR_CMP = 1'b0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic                 clr,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [15:0]          bus_addr,
  input logic [CW-1:0]        cnt_q,
  input logic [NHARTS*CW-1:0] cmp_q,
  input logic [NHARTS-1:0]    mtip,
  input logic [NHARTS-1:0]    msip
);
  logic cnt_wr;
  assign cnt_wr = bus_en && bus_we && (bus_addr == 16'hBFF8 || bus_addr == 16'hBFFC);

  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R1
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && !cnt_wr) |=> $stable(cnt_q));

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R4
  clr_soft_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (msip == '0));

  // R3
  clr_cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !CLR_CMP) |=> $stable(cmp_q));

  for (genvar h = 0; h < NHARTS; h++) begin : g_h
    // R6
    mtip_match_chk: assert property (@(posedge clk) disable iff (rst)
      mtip[h] == (cnt_q >= cmp_q[h*CW +: CW]));
  end
endmodule

bind hart_timer_unit htu_chk #(.NHARTS(NHARTS), .CW(2*DW), .CLR_CMP(CLR_CMP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_i),
  .clr      (clr_req_i),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .cnt_q    (cnt_q),
  .cmp_q    (cmp_q),
  .mtip     (mtip_o),
  .msip     (msip_o)
);

// File: tb/sim_hart_timer_unit.sv
`timescale 1ns/1ps
module sim_hart_timer_unit;
  localparam int unsigned N  = 4;
  localparam int unsigned DW = 32;
  localparam bit          CC = 1'b0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0, clr_req_i = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  mtip_o, msip_o;

  int checks = 0, errors = 0;

  logic [63:0] m_cnt;
  logic [63:0] m_cmp [N];
  logic [N-1:0] m_sw;

  hart_timer_unit #(.NHARTS(N), .DW(DW), .CLR_CMP(CC)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .clr_req_i(clr_req_i),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .mtip_o(mtip_o), .msip_o(msip_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [15:0] a);
    logic [31:0] r = '0;
    if (a == 16'hBFF8) r = m_cnt[31:0];
    if (a == 16'hBFFC) r = m_cnt[63:32];
    for (int h = 0; h < N; h++) begin
      if (a == 16'(4*h))           r = {31'b0, m_sw[h]};
      if (a == 16'(16'h4000+8*h))  r = m_cmp[h][31:0];
      if (a == 16'(16'h4004+8*h))  r = m_cmp[h][63:32];
    end
    return r;
  endfunction

  task automatic model_step(input bit tk, input bit cl, input bit en, input bit we,
                            input logic [15:0] a, input logic [31:0] d);
    bit cw;
    cw = en && we && (a == 16'hBFF8 || a == 16'hBFFC);
    if (cl) begin
      m_cnt = '0;
      m_sw  = '0;
      if (CC) for (int h = 0; h < N; h++) m_cmp[h] = '0;
    end else begin
      if (en && we) begin
        if (a == 16'hBFF8) m_cnt[31:0]  = d;
        if (a == 16'hBFFC) m_cnt[63:32] = d;
        for (int h = 0; h < N; h++) begin
          if (a == 16'(4*h))          m_sw[h] = d[0];
          if (a == 16'(16'h4000+8*h)) m_cmp[h][31:0]  = d;
          if (a == 16'(16'h4004+8*h)) m_cmp[h][63:32] = d;
        end
      end
      if (tk && !cw) m_cnt = m_cnt + 64'd1;
    end
  endtask

  // One clock cycle: drive, update model at the edge, check after it.
  task automatic cyc(input bit tk, input bit cl, input bit en, input bit we,
                     input logic [15:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    logic [N-1:0] exp_mt;
    @(negedge clk);
    tick_i = tk; clr_req_i = cl; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    exp_rd = model_rd(a);
    model_step(tk, cl, en, we, a, d);
    @(posedge clk);
    #1;
    for (int h = 0; h < N; h++) exp_mt[h] = (m_cnt >= m_cmp[h]);
    chk(mtip_o == exp_mt, cl ? "R5 mtip after clear" : "R6 mtip compare", 64'(mtip_o), 64'(exp_mt));
    chk(msip_o == m_sw, cl ? "R4 msip clear" : "R9 msip bit0", 64'(msip_o), 64'(m_sw));
    chk(bus_rvalid == (en && !we), "R10 rvalid", 64'(bus_rvalid), 64'(en && !we));
    if (en && !we)
      chk(bus_rdata == exp_rd, tag, 64'(bus_rdata), 64'(exp_rd));
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, "idle");
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit tk);
    cyc(tk, 1'b0, 1'b1, 1'b1, a, d, "R8 write");
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    m_cnt = '0; m_sw = '0;
    for (int h = 0; h < N; h++) m_cmp[h] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state
    chk(mtip_o == '0 && msip_o == '0 && bus_rvalid == 1'b0, "R11 reset outputs",
        {mtip_o, msip_o, 7'b0, bus_rvalid}, 64'h0);
    rd(16'hBFF8, "R11 counter reset");
    rd(16'h4004, "R3 compare reset all ones");

    // R6 boundary: compare 3, three ticks
    wr(16'h4000, 32'd3, 1'b0);
    wr(16'h4004, 32'd0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    chk(mtip_o[0] == 1'b0, "R6 below compare", 64'(mtip_o[0]), 64'd0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    chk(mtip_o[0] == 1'b1, "R6 equal compare", 64'(mtip_o[0]), 64'd1);
    rd(16'hBFF8, "R1 three ticks");

    // R8 counter write beats tick
    wr(16'hBFF8, 32'h100, 1'b1);
    rd(16'hBFF8, "R8 write beats tick");

    // R1 carry into high word
    wr(16'hBFF8, 32'hFFFF_FFFF, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, "R1");
    rd(16'hBFFC, "R1 carry high word");
    rd(16'hBFF8, "R1 carry low word");

    // R9 upper pending bits
    wr(16'h0004, 32'hFFFF_FFFE, 1'b0);
    chk(msip_o[1] == 1'b0, "R9 bit0 clear", 64'(msip_o[1]), 64'd0);
    wr(16'h0004, 32'hFFFF_FFFF, 1'b0);
    rd(16'h0004, "R9 upper bits read zero");

    // R7 map: compare 2 = 0, high word of compare 3
    wr(16'h4010, 32'h0, 1'b0);
    wr(16'h4014, 32'h0, 1'b0);
    wr(16'h401C, 32'h1234_5678, 1'b0);
    rd(16'h401C, "R7 compare high word");
    rd(16'h4018, "R7 compare low word");

    // R2 R3 R4 R5 clear with tick in same cycle
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'hBFF8, 32'h55, "R2");
    chk(mtip_o == 4'b0100, "R5 recompute", 64'(mtip_o), 64'h4);
    rd(16'hBFF8, "R2 R5 counter zero no tick");
    rd(16'hBFFC, "R2 counter high zero");
    rd(16'h4000, "R3 compare kept");
    rd(16'h1000, "R10 unmapped reads zero");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit tk, cl, en, we;
      logic [15:0] a;
      logic [31:0] d;
      int unsigned sel, h;
      tk = ($urandom % 2) == 0;
      cl = ($urandom % 64) == 0;
      en = ($urandom % 3) != 0;
      we = ($urandom % 2) == 0;
      sel = $urandom % 8;
      h = $urandom % N;
      case (sel)
        0: a = 16'(4*h);
        1, 2: a = 16'(16'h4000 + 8*h);
        3: a = 16'(16'h4004 + 8*h);
        4: a = 16'hBFF8;
        5: a = 16'hBFFC;
        6: a = 16'h2000;
        default: a = 16'(16'h4000 + 8*h);
      endcase
      if (a[15:12] == 4'h4 && !a[2]) d = m_cnt[31:0] + ($urandom % 8);
      else if (a == 16'hBFF8) d = $urandom % 16;
      else if ($urandom % 2 == 0) d = 32'h0;
      else d = $urandom;
      cyc(tk, cl, en, we, a, d, "R10 random read");
    end
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule